// File: doc/BRIEF.md
# Pointer Indirect Address Generator

This block turns a memory-access request into a data or program memory address using one of three 16-bit pointers, each assembled from a low and a high byte of a register pair. The register file and the memories sit outside it. The pair bytes come in on two flattened buses, and the updated pointer goes back out on a write-back port.

A request is a one-cycle `start` pulse that carries a pointer select, an addressing mode, an unsigned 6-bit displacement and a 16-bit direct address. The block latches everything it needs on the accepting edge and then runs a fixed-length access. It drives the address and a one-cycle memory strobe in the first cycle, and `done` in the last cycle. In that same last cycle it raises write-back for the modes that move the pointer.

A request that names displacement on a pointer not allowed to take one, an unused pointer select, or the reserved mode code is refused. The block raises a one-cycle illegal flag and issues no strobe.

Top module: `ptr_agu`

## Requirements
- R1: Mode 0 (plain) addresses memory at the selected pointer unchanged. Pointer select 0 is X, 1 is Y and 2 is Z. The pointer is {high byte, low byte}, with pointer i taking bits [8i+7:8i] of each pair bus. There is no write-back.
- R2: Mode 1 (post-increment) addresses at the current pointer. It writes back pointer+1 modulo 2^16, so 0xFFFF wraps to 0x0000.
- R3: Mode 2 (pre-decrement) addresses at pointer-1 modulo 2^16 and writes back that same value.
- R4: Mode 3 (displacement) addresses at pointer+q, with q unsigned 0..63 and the sum taken modulo 2^16, for Y and Z only. There is no write-back.
- R5: A refused request raises `illegal` for exactly the cycle after the accepting edge, with no strobe, no busy, no done and no write-back. Refused requests are mode 3 with select 0, any of modes 0..3 with select 3, and mode 7.
- R6: Mode 4 (direct) addresses at `direct_addr` and ignores the pointer select, including select 3.
- R7: A data access (modes 0..4) keeps `busy` high for 2 cycles after the accepting edge. `mem_stb` is high in the first of them and `done` in the second, and the address is held through both.
- R8: Modes 5 and 6 read program memory at Z whatever the select, with `mem_prog` high. They keep `busy` high for 3 cycles, with `done` in the third. Mode 6 also writes back Z+1.
- R9: `wb_en` is high only in the `done` cycle of modes 1, 2 and 6, and `wb_sel` then names the written pointer.
- R10: `start` while `busy` is ignored, and pointer inputs that change after the accepting edge do not affect the access in progress.
- R11: After reset, `busy`, `mem_stb`, `done`, `wb_en`, `illegal` and `mem_prog` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| mode | input | 3 | Addressing mode code |
| disp | input | 6 | Unsigned displacement q |
| direct_addr | input | 16 | Direct address k |
| pair_lo | input | 24 | Low bytes of the three pointer pairs |
| pair_hi | input | 24 | High bytes of the three pointer pairs |
| mem_addr | output | 16 | Memory address of the access |
| mem_stb | output | 1 | One-cycle memory strobe |
| mem_prog | output | 1 | Access targets program memory |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last cycle of the access |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer being written back |
| wb_ptr | output | 16 | New pointer value |
| illegal | output | 1 | Refused request flag |

## Verification
The hardest situations to reach from the ports are the two wrap points at the ends of the address space: a post-increment from 0xFFFF, a pre-decrement from 0x0000, and a displacement that carries past 0xFFFF. Random 16-bit pointers almost never land on them, so directed requests set those exact pointer values. A second hard case is a new `start` that arrives in the middle of a busy access while the pointer buses change at the same time. Some random requests do this on purpose, and the bench then checks that the address and the write-back still reflect the values latched at the accepting edge.

// File: rtl/agu_pkg.sv
package agu_pkg;
   localparam int SEL_W  = 2;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      AM_PLAIN   = 3'd0,
      AM_POSTINC = 3'd1,
      AM_PREDEC  = 3'd2,
      AM_DISP    = 3'd3,
      AM_DIRECT  = 3'd4,
      AM_PROG    = 3'd5,
      AM_PROGINC = 3'd6,
      AM_RSVD    = 3'd7
   } amode_e;
endpackage

// File: rtl/agu_ptr_bank.sv
module agu_ptr_bank #(
   parameter int BYTE_W  = 8,
   parameter int NUM_PTR = 3,
   localparam int AW     = 2 * BYTE_W
) (
   input  logic [NUM_PTR*BYTE_W-1:0] pair_lo,
   input  logic [NUM_PTR*BYTE_W-1:0] pair_hi,
   output logic [NUM_PTR-1:0][AW-1:0] ptrs
);
   for (genvar i = 0; i < NUM_PTR; i++) begin : g_pair
      assign ptrs[i] = {pair_hi[i*BYTE_W +: BYTE_W], pair_lo[i*BYTE_W +: BYTE_W]};
   end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
   import agu_pkg::*;
#(
   parameter int              AW        = 16,
   parameter int              NUM_PTR   = 3,
   parameter int              DISP_W    = 6,
   parameter logic [NUM_PTR-1:0] DISP_OK = 3'b110,
   parameter int              PROG_PTR  = 2,
   parameter int              DATA_CYC  = 2,
   parameter int              PROG_CYC  = 3,
   localparam int             CNT_W     = $clog2(PROG_CYC + 1)
) (
   input  logic [NUM_PTR-1:0][AW-1:0] ptrs,
   input  logic [SEL_W-1:0]           sel,
   input  logic [MODE_W-1:0]          mode,
   input  logic [DISP_W-1:0]          disp,
   input  logic [AW-1:0]              direct_addr,
   output logic                       legal,
   output logic [AW-1:0]              eff_addr,
   output logic [AW-1:0]              new_ptr,
   output logic                       need_wb,
   output logic [SEL_W-1:0]           wb_sel,
   output logic                       prog,
   output logic [CNT_W-1:0]           cycles
);
   logic          sel_ok;
   logic [AW-1:0] cur;
   logic [AW-1:0] zptr;
   logic [AW-1:0] minus1;

   assign sel_ok = (int'(sel) < NUM_PTR);
   assign cur    = sel_ok ? ptrs[sel] : '0;
   assign zptr   = ptrs[PROG_PTR];
   assign minus1 = cur - AW'(1);

   always_comb begin
      legal    = 1'b1;
      eff_addr = cur;
      new_ptr  = cur;
      need_wb  = 1'b0;
      wb_sel   = sel;
      prog     = 1'b0;
      cycles   = CNT_W'(DATA_CYC);
      unique case (amode_e'(mode))
         AM_PLAIN: legal = sel_ok;
         AM_POSTINC: begin
            legal   = sel_ok;
            new_ptr = cur + AW'(1);
            need_wb = 1'b1;
         end
         AM_PREDEC: begin
            legal    = sel_ok;
            eff_addr = minus1;
            new_ptr  = minus1;
            need_wb  = 1'b1;
         end
         AM_DISP: begin
            legal    = sel_ok && DISP_OK[sel];
            eff_addr = cur + AW'(disp);
         end
         AM_DIRECT: eff_addr = direct_addr;
         AM_PROG, AM_PROGINC: begin
            eff_addr = zptr;
            new_ptr  = zptr + AW'(1);
            need_wb  = (amode_e'(mode) == AM_PROGINC);
            wb_sel   = SEL_W'(PROG_PTR);
            prog     = 1'b1;
            cycles   = CNT_W'(PROG_CYC);
         end
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
   import agu_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             legal,
   input  logic [AW-1:0]    eff_addr,
   input  logic [AW-1:0]    new_ptr,
   input  logic             need_wb,
   input  logic [SEL_W-1:0] wb_sel_in,
   input  logic             prog,
   input  logic [CNT_W-1:0] cycles,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_stb,
   output logic             mem_prog,
   output logic             busy,
   output logic             done,
   output logic             wb_en,
   output logic [SEL_W-1:0] wb_sel,
   output logic [AW-1:0]    wb_ptr,
   output logic             illegal
);
   logic             busy_q, need_q, prog_q, bad_q;
   logic [CNT_W-1:0] cnt_q, total_q;
   logic [AW-1:0]    addr_q, ptr_q;
   logic [SEL_W-1:0] sel_q;
   logic             last;

   assign last = busy_q && (cnt_q == total_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         need_q  <= 1'b0;
         prog_q  <= 1'b0;
         bad_q   <= 1'b0;
         cnt_q   <= '0;
         total_q <= '0;
         addr_q  <= '0;
         ptr_q   <= '0;
         sel_q   <= '0;
      end else begin
         bad_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               if (legal) begin
                  busy_q  <= 1'b1;
                  cnt_q   <= CNT_W'(1);
                  total_q <= cycles;
                  addr_q  <= eff_addr;
                  ptr_q   <= new_ptr;
                  need_q  <= need_wb;
                  sel_q   <= wb_sel_in;
                  prog_q  <= prog;
               end else begin
                  bad_q <= 1'b1;
               end
            end
         end else if (last) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            prog_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign mem_addr = addr_q;
   assign mem_stb  = busy_q && (cnt_q == CNT_W'(1));
   assign mem_prog = prog_q;
   assign busy     = busy_q;
   assign done     = last;
   assign wb_en    = last && need_q;
   assign wb_sel   = sel_q;
   assign wb_ptr   = ptr_q;
   assign illegal  = bad_q;
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
   import agu_pkg::*;
#(
   parameter int              BYTE_W   = 8,
   parameter int              NUM_PTR  = 3,
   parameter int              DISP_W   = 6,
   parameter logic [NUM_PTR-1:0] DISP_OK = 3'b110,
   parameter int              DATA_CYC = 2,
   parameter int              PROG_CYC = 3,
   localparam int             AW       = 2 * BYTE_W,
   localparam int             PROG_PTR = NUM_PTR - 1,
   localparam int             CNT_W    = $clog2(PROG_CYC + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [SEL_W-1:0]          ptr_sel,
   input  logic [MODE_W-1:0]         mode,
   input  logic [DISP_W-1:0]         disp,
   input  logic [AW-1:0]             direct_addr,
   input  logic [NUM_PTR*BYTE_W-1:0] pair_lo,
   input  logic [NUM_PTR*BYTE_W-1:0] pair_hi,
   output logic [AW-1:0]             mem_addr,
   output logic                      mem_stb,
   output logic                      mem_prog,
   output logic                      busy,
   output logic                      done,
   output logic                      wb_en,
   output logic [SEL_W-1:0]          wb_sel,
   output logic [AW-1:0]             wb_ptr,
   output logic                      illegal
);
   if (DATA_CYC < 2) begin : g_chk_data
      $error("DATA_CYC must be at least 2");
   end
   if (PROG_CYC < DATA_CYC) begin : g_chk_prog
      $error("PROG_CYC must not be shorter than DATA_CYC");
   end
   if (NUM_PTR > (1 << SEL_W)) begin : g_chk_ptr
      $error("NUM_PTR exceeds the select width");
   end
   if (DISP_W >= AW) begin : g_chk_disp
      $error("DISP_W must be narrower than the address");
   end

   logic [NUM_PTR-1:0][AW-1:0] ptrs;
   logic                       c_legal, c_need, c_prog;
   logic [AW-1:0]              c_addr, c_new;
   logic [SEL_W-1:0]           c_sel;
   logic [CNT_W-1:0]           c_cyc;

   agu_ptr_bank #(.BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR)) u_bank (
      .pair_lo(pair_lo), .pair_hi(pair_hi), .ptrs(ptrs)
   );

   agu_addr_calc #(
      .AW(AW), .NUM_PTR(NUM_PTR), .DISP_W(DISP_W), .DISP_OK(DISP_OK),
      .PROG_PTR(PROG_PTR), .DATA_CYC(DATA_CYC), .PROG_CYC(PROG_CYC)
   ) u_calc (
      .ptrs(ptrs), .sel(ptr_sel), .mode(mode), .disp(disp),
      .direct_addr(direct_addr), .legal(c_legal), .eff_addr(c_addr),
      .new_ptr(c_new), .need_wb(c_need), .wb_sel(c_sel), .prog(c_prog),
      .cycles(c_cyc)
   );

   agu_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .legal(c_legal),
      .eff_addr(c_addr), .new_ptr(c_new), .need_wb(c_need),
      .wb_sel_in(c_sel), .prog(c_prog), .cycles(c_cyc),
      .mem_addr(mem_addr), .mem_stb(mem_stb), .mem_prog(mem_prog),
      .busy(busy), .done(done), .wb_en(wb_en), .wb_sel(wb_sel),
      .wb_ptr(wb_ptr), .illegal(illegal)
   );
endmodule

// File: rtl/agu_checker.sv
module agu_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] mem_addr,
   input logic        mem_stb,
   input logic        mem_prog,
   input logic        busy,
   input logic        done,
   input logic        wb_en,
   input logic [1:0]  wb_sel,
   input logic        illegal
);
   // R7: strobe only inside an access
   a_r7_stb_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_stb |-> busy);
   // R7: address held while the access runs
   a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(done)) |-> $stable(mem_addr));
   // R10: no second strobe directly after the first
   a_r10_no_restrobe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_stb |=> !mem_stb);
   // R5: refused request makes no access
   a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!mem_stb && !busy && !done && !wb_en));
   // R9: write-back only at the end
   a_r9_wb_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> done);
   // R8: program write-back goes to Z, done lands late
   a_r8_prog_wb_z: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && mem_prog) |-> (wb_sel == 2'd2));
   a_r8_prog_three: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mem_prog) |-> ($past(busy) && $past(busy, 2)));
   // R7: access ends after done
   a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind ptr_agu agu_checker u_chk (
   .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_stb(mem_stb),
   .mem_prog(mem_prog), .busy(busy), .done(done), .wb_en(wb_en),
   .wb_sel(wb_sel), .illegal(illegal)
);

// File: tb/sim_ptr_agu.sv
module sim_ptr_agu;
   localparam time TCLK = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  ptr_sel = '0;
   logic [2:0]  mode = '0;
   logic [5:0]  disp = '0;
   logic [15:0] direct_addr = '0;
   logic [15:0] px = '0, py = '0, pz = '0;
   logic [23:0] pair_lo, pair_hi;
   logic [15:0] mem_addr, wb_ptr;
   logic        mem_stb, mem_prog, busy, done, wb_en, illegal;
   logic [1:0]  wb_sel;

   int n_chk = 0;
   int n_bad = 0;

   assign pair_lo = {pz[7:0], py[7:0], px[7:0]};
   assign pair_hi = {pz[15:8], py[15:8], px[15:8]};

   always #(TCLK/2) clk = ~clk;

   ptr_agu u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .ptr_sel(ptr_sel),
      .mode(mode), .disp(disp), .direct_addr(direct_addr),
      .pair_lo(pair_lo), .pair_hi(pair_hi), .mem_addr(mem_addr),
      .mem_stb(mem_stb), .mem_prog(mem_prog), .busy(busy), .done(done),
      .wb_en(wb_en), .wb_sel(wb_sel), .wb_ptr(wb_ptr), .illegal(illegal)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pick(input logic [1:0] s);
      return (s == 2'd0) ? px : (s == 2'd1) ? py : pz;
   endfunction

   function automatic bit is_legal(input logic [1:0] s, input logic [2:0] m);
      if (m == 3'd7) return 0;
      if (m <= 3'd3 && s == 2'd3) return 0;
      if (m == 3'd3 && s == 2'd0) return 0;
      return 1;
   endfunction

   task automatic access(input logic [1:0] s, input logic [2:0] m,
                         input logic [5:0] q, input logic [15:0] k,
                         input bit poke);
      logic [15:0] p, ea, np;
      logic [1:0]  es;
      bit need, prg, ok;
      int cyc;
      string rq;
      ok   = is_legal(s, m);
      prg  = (m == 3'd5 || m == 3'd6);
      p    = prg ? pz : pick(s);
      ea   = p; np = p; need = 0; es = prg ? 2'd2 : s;
      cyc  = prg ? 3 : 2;
      case (m)
         3'd1: begin np = p + 16'd1; need = 1; rq = "R2"; end
         3'd2: begin ea = p - 16'd1; np = ea; need = 1; rq = "R3"; end
         3'd3: begin ea = p + {10'd0, q}; rq = "R4"; end
         3'd4: begin ea = k; rq = "R6"; end
         3'd5: rq = "R8";
         3'd6: begin np = p + 16'd1; need = 1; rq = "R8"; end
         default: rq = "R1";
      endcase
      @(negedge clk);
      ptr_sel = s; mode = m; disp = q; direct_addr = k; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (!ok) begin
         chk(illegal && !mem_stb && !busy, "R5", "illegal pulse",
             {illegal, mem_stb, busy}, 3'b100);
         @(negedge clk);
         chk(!illegal && !done && !wb_en && !busy, "R5", "illegal one cycle",
             {illegal, done, wb_en, busy}, 4'b0);
         return;
      end
      for (int c = 1; c <= cyc; c++) begin
         start = 1'b0;
         chk(busy, "R7", "busy", busy, 1);
         chk(mem_stb == (c == 1), "R7", "strobe", mem_stb, (c == 1));
         chk(done == (c == cyc), prg ? "R8" : "R7", "done", done, (c == cyc));
         chk(mem_addr == ea, rq, "address", mem_addr, ea);
         chk(mem_prog == prg, "R8", "prog flag", mem_prog, prg);
         chk(wb_en == (need && c == cyc), "R9", "wb_en", wb_en, (need && c == cyc));
         if (wb_en) begin
            chk(wb_ptr == np, rq, "wb value", wb_ptr, np);
            chk(wb_sel == es, "R9", "wb select", wb_sel, es);
         end
         if (poke && c == 1) begin
            // R10: start during busy with scrambled pointers
            start = 1'b1; mode = 3'd1; ptr_sel = 2'd0;
            px = $urandom; py = $urandom; pz = $urandom;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(!busy && !mem_stb, poke ? "R10" : "R7", "idle after access",
          {busy, mem_stb}, 2'b0);
   endtask

   initial begin
      int wd = 0;
      forever begin
         @(posedge clk);
         wd++;
         if (wd > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000", wd);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5EED_0A6C));
      repeat (3) @(negedge clk);
      chk({busy, mem_stb, done, wb_en, illegal, mem_prog} == 6'b0, "R11",
          "reset outputs", {busy, mem_stb, done, wb_en, illegal, mem_prog}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      px = 16'hFFFF; access(2'd0, 3'd1, 6'd0, 16'h0, 0);      // R2 wrap
      py = 16'h0000; access(2'd1, 3'd2, 6'd0, 16'h0, 0);      // R3 wrap
      pz = 16'hFFF0; access(2'd2, 3'd3, 6'd63, 16'h0, 0);     // R4 wrap
      py = 16'h1234; access(2'd1, 3'd3, 6'd0, 16'h0, 0);      // R4 q=0
      access(2'd0, 3'd3, 6'd5, 16'h0, 0);                     // R5 X disp
      access(2'd3, 3'd0, 6'd0, 16'h0, 0);                     // R5 sel 3
      access(2'd1, 3'd7, 6'd0, 16'h0, 0);                     // R5 reserved
      access(2'd3, 3'd4, 6'd0, 16'hBEEF, 0);                  // R6 sel ignored
      pz = 16'hFFFF; access(2'd0, 3'd6, 6'd0, 16'h0, 0);      // R8 wrap, sel ignored
      px = 16'h0100; access(2'd0, 3'd0, 6'd0, 16'h0, 1);      // R1 + R10
      for (int i = 0; i < 400; i++) begin
         logic [1:0] s;
         logic [2:0] m;
         px = $urandom; py = $urandom; pz = $urandom;
         s = 2'($urandom_range(0, 3));
         m = 3'($urandom_range(0, 7));
         access(s, m, 6'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0));
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule